// File: doc/BRIEF.md
# Quasi-Resonant Valley-Skipping Turn-On Sequencer

This block decides the cycle in which the power switch of a quasi-resonant flyback converter is switched on. It works on comparator outputs that have already been digitised. One comparator reports that the demagnetisation sense voltage is above the high threshold, and another reports that it is above the low threshold. The other inputs are a current-sense trip, a flag for a saturated control loop and a flag for active soft start. A valley turn-on needs two edges in order. First the sense voltage must rise through the high threshold, which arms the stage. Then it must fall through the low threshold. The falling edge counts only when a full oscillator period has passed since the previous turn-on, so ringing valleys that come too early are skipped. A valley turn-on waits a programmable number of cycles, so that the switch closes at the bottom of the valley, and it restarts the oscillator.

The oscillator also works as a fallback starter. When no valid valley arrives, the switch is turned on when a period ends, so at most one oscillator period is skipped. After a turn-off, a blanking window rejects the ringing of the leakage inductance. When the loop saturates, a noise pull-up is enabled during the off-time and the fallback period grows by a fixed factor. During soft start the pull-up stays off.

Top module: `qrt_turnon_seq`

## Requirements
- R1: While `rst` is high, `gate`, `osc_restart` and `pullup_en` are low, and all counters are cleared.
- R2: With the sense inputs held low after reset, the first turn-on happens at the end of the first oscillator period. `gate` is high after exactly `OSC_PERIOD` clock edges following the release of reset, and low before that.
- R3: A valley turn-on needs `zcd_above_hi` to go 0→1 (arm), then `zcd_above_lo` to go 1→0 (trigger). `gate` rises `ON_DELAY` edges after the edge that samples the trigger.
- R4: A trigger sampled less than one oscillator period after the last turn-on is discarded. The first valid trigger after that turns the switch on and restarts the oscillator phase.
- R5: With no valid trigger, the switch turns on at the second period end after the last turn-on, which is `2*OSC_PERIOD` edges later.
- R6: `gate` goes low in the same cycle that `cs_trip` is high, and this turn-off starts the blanking window.
- R7: For `BLANK_CYC` edges after a turn-off, arm edges and trigger edges are ignored, and a fallback that falls due inside the window fires on the first edge after it ends.
- R8: With `loop_sat` high and `soft_start` low, `pullup_en` is high during the off-time and low while the switch is on, and the oscillator period is `OSC_PERIOD*SAT_DIV`.
- R9: `pullup_en` is low one cycle after `soft_start` is sampled high, whatever the value of `loop_sat`.
- R10: `osc_restart` is high for the cycle after every period end and after every turn-on.
- R11: The arm state is cleared by every turn-on and every turn-off, so a trigger after a turn-off needs a fresh arm edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| zcd_above_hi | input | 1 | Sense voltage above arming threshold |
| zcd_above_lo | input | 1 | Sense voltage above trigger threshold |
| cs_trip | input | 1 | Current-sense trip, ends on-time |
| loop_sat | input | 1 | Control loop saturated |
| soft_start | input | 1 | Soft start in progress |
| gate | output | 1 | Power switch drive |
| osc_restart | output | 1 | Oscillator period restart strobe |
| pullup_en | output | 1 | Enable for the open-loop noise pull-up |

## Verification
A valley delay can still be counting down on the clock edge where the oscillator period ends and a fallback falls due. The bench sets this up by placing the trigger edge two cycles before the wrap. It then checks that the switch turns on only once, at the end of the delay, and that the strobe pulses for both the wrap and the turn-on. It also checks that the pending fallback is gone, because no second turn-on follows the next blanking window.

// File: rtl/qrt_pkg.sv
package qrt_pkg;

  typedef enum logic [1:0] {
    ON_NONE     = 2'd0,
    ON_VALLEY   = 2'd1,
    ON_FALLBACK = 2'd2
  } on_src_e;

  // bits needed to hold the values 0 .. n-1
  function automatic int unsigned cnt_width(int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/qrt_osc.sv
module qrt_osc #(
  parameter int unsigned PERIOD  = 40,
  parameter int unsigned SAT_DIV = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic loop_sat,
  input  logic restart,
  output logic wrap,
  output logic period_ok,
  output logic strobe
);
  localparam int unsigned SLOW = PERIOD * SAT_DIV;
  localparam int unsigned PW   = qrt_pkg::cnt_width(SLOW);
  localparam logic [PW-1:0] LAST_FAST = PW'(PERIOD - 1);
  localparam logic [PW-1:0] LAST_SLOW = PW'(SLOW - 1);

  logic [PW-1:0] ph_q;
  logic [PW-1:0] last;

  assign last = loop_sat ? LAST_SLOW : LAST_FAST;
  assign wrap = (ph_q >= last);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q      <= '0;
      period_ok <= 1'b1;
      strobe    <= 1'b0;
    end else begin
      strobe <= wrap | restart;
      if (restart) begin
        ph_q      <= '0;
        period_ok <= 1'b0;
      end else if (wrap) begin
        ph_q      <= '0;
        period_ok <= 1'b1;
      end else begin
        ph_q <= ph_q + PW'(1);
      end
    end
  end

  p_phase_bound_r10: assert property (@(posedge clk) disable iff (rst)
    ph_q <= LAST_SLOW);

  p_restart_clears_ok_r4: assert property (@(posedge clk) disable iff (rst)
    restart |=> (!period_ok && strobe));

endmodule

// File: rtl/qrt_blank.sv
module qrt_blank #(
  parameter int unsigned LEN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic active
);
  generate
    if (LEN == 0) begin : g_none
      assign active = 1'b0;
    end else begin : g_cnt
      localparam int unsigned BW = qrt_pkg::cnt_width(LEN + 1);
      localparam logic [BW-1:0] LOAD = BW'(LEN);
      logic [BW-1:0] cnt_q;

      always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (start)        cnt_q <= LOAD;
        else if (cnt_q != '0)  cnt_q <= cnt_q - BW'(1);
      end

      assign active = (cnt_q != '0);

      p_blank_follows_off_r7: assert property (@(posedge clk) disable iff (rst)
        start |=> active);
    end
  endgenerate
endmodule

// File: rtl/qrt_arm.sv
module qrt_arm (
  input  logic clk,
  input  logic rst,
  input  logic zcd_hi,
  input  logic zcd_lo,
  input  logic inhibit,
  input  logic clear,
  output logic armed,
  output logic fall
);
  logic hi_q, lo_q;

  assign fall = lo_q & ~zcd_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q  <= 1'b0;
      lo_q  <= 1'b0;
      armed <= 1'b0;
    end else begin
      hi_q <= zcd_hi;
      lo_q <= zcd_lo;
      if (clear)                          armed <= 1'b0;
      else if (~hi_q & zcd_hi & ~inhibit) armed <= 1'b1;
    end
  end

  p_clear_drops_arm_r11: assert property (@(posedge clk) disable iff (rst)
    clear |=> !armed);

  p_arm_when_open_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(armed) |-> $past(!inhibit));

endmodule

// File: rtl/qrt_delay.sv
module qrt_delay #(
  parameter int unsigned DLY = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic done,
  output logic busy
);
  generate
    if (DLY == 0) begin : g_direct
      assign done = fire;
      assign busy = 1'b0;
    end else begin : g_cnt
      localparam int unsigned DW = qrt_pkg::cnt_width(DLY + 1);
      localparam logic [DW-1:0] LOAD = DW'(DLY);
      logic [DW-1:0] cnt_q;

      always_ff @(posedge clk) begin
        if (rst)                      cnt_q <= '0;
        else if (cnt_q != '0)         cnt_q <= cnt_q - DW'(1);
        else if (fire)                cnt_q <= LOAD;
      end

      assign busy = (cnt_q != '0);
      assign done = (cnt_q == DW'(1));

      p_delay_holds_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);
    end
  endgenerate
endmodule

// File: rtl/qrt_turnon_seq.sv
module qrt_turnon_seq #(
  parameter int unsigned OSC_PERIOD = 40,
  parameter int unsigned SAT_DIV    = 128,
  parameter int unsigned BLANK_CYC  = 8,
  parameter int unsigned ON_DELAY   = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic zcd_above_hi,
  input  logic zcd_above_lo,
  input  logic cs_trip,
  input  logic loop_sat,
  input  logic soft_start,
  output logic gate,
  output logic osc_restart,
  output logic pullup_en
);
  import qrt_pkg::*;

  logic    gate_q, gate_nxt, due_q;
  logic    wrap, period_ok, blank_act;
  logic    armed, fall, dly_done, dly_busy;
  logic    turn_off, turn_on, fire, fb_req, fb_go;
  on_src_e on_src;

  qrt_osc #(.PERIOD(OSC_PERIOD), .SAT_DIV(SAT_DIV)) u_osc (
    .clk(clk), .rst(rst), .loop_sat(loop_sat), .restart(turn_on),
    .wrap(wrap), .period_ok(period_ok), .strobe(osc_restart));

  qrt_blank #(.LEN(BLANK_CYC)) u_blank (
    .clk(clk), .rst(rst), .start(turn_off), .active(blank_act));

  qrt_arm u_arm (
    .clk(clk), .rst(rst), .zcd_hi(zcd_above_hi), .zcd_lo(zcd_above_lo),
    .inhibit(blank_act | gate_q | dly_busy), .clear(turn_on | turn_off),
    .armed(armed), .fall(fall));

  qrt_delay #(.DLY(ON_DELAY)) u_delay (
    .clk(clk), .rst(rst), .fire(fire), .done(dly_done), .busy(dly_busy));

  assign turn_off = gate_q & cs_trip;
  assign fb_req   = due_q | (wrap & period_ok & ~gate_q);
  assign fb_go    = fb_req & ~blank_act & ~dly_busy & ~gate_q;
  assign fire     = fall & armed & period_ok & ~blank_act & ~gate_q
                    & ~dly_busy & ~fb_go;

  always_comb begin
    if (dly_done)   on_src = ON_VALLEY;
    else if (fb_go) on_src = ON_FALLBACK;
    else            on_src = ON_NONE;
  end

  assign turn_on  = (on_src != ON_NONE);
  assign gate_nxt = turn_on ? 1'b1 : (turn_off ? 1'b0 : gate_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q    <= 1'b0;
      due_q     <= 1'b0;
      pullup_en <= 1'b0;
    end else begin
      gate_q    <= gate_nxt;
      due_q     <= turn_on ? 1'b0 : fb_req;
      pullup_en <= loop_sat & ~soft_start & ~gate_nxt;
    end
  end

  // fast current-limit path: trip removes drive without waiting for a clock
  assign gate = gate_q & ~cs_trip;

  p_trip_starts_blank_r6: assert property (@(posedge clk) disable iff (rst)
    turn_off |=> (!gate_q && (blank_act || BLANK_CYC == 0)));

  p_no_pullup_when_on_r8: assert property (@(posedge clk) disable iff (rst)
    gate_q |-> !pullup_en);

  p_softstart_mutes_pullup_r9: assert property (@(posedge clk) disable iff (rst)
    $past(soft_start) |-> !pullup_en);

  p_on_outside_blank_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_q) |-> $past(!blank_act));

  p_on_restarts_osc_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_q) |-> osc_restart);

  p_on_time_unarmed_r11: assert property (@(posedge clk) disable iff (rst)
    gate_q |-> !armed);

endmodule

// File: tb/sim_qrt_turnon_seq.sv
module sim_qrt_turnon_seq;
  localparam int P = 40, DIV = 128, B = 8, D = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic hi = 1'b0, lo = 1'b0, cs = 1'b0, sat = 1'b0, ss = 1'b0;
  logic gate, strobe, pu;
  int   n_chk = 0, n_fail = 0, ncyc = 0;
  bit   finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  qrt_turnon_seq #(.OSC_PERIOD(P), .SAT_DIV(DIV), .BLANK_CYC(B), .ON_DELAY(D)) u0 (
    .clk(clk), .rst(rst), .zcd_above_hi(hi), .zcd_above_lo(lo), .cs_trip(cs),
    .loop_sat(sat), .soft_start(ss), .gate(gate), .osc_restart(strobe),
    .pullup_en(pu));

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b (cycle %0d)", req, act, exp, ncyc);
    end
  endtask

  task automatic adv(int n);
    repeat (n) @(negedge clk);
    ncyc += n;
  endtask

  task automatic goto(int k);
    if (k > ncyc) adv(k - ncyc);
  endtask

  task automatic do_reset(logic s, logic f);
    rst = 1'b1; hi = 1'b0; lo = 1'b0; cs = 1'b0; sat = s; ss = f;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    ncyc = 0;
  endtask

  task automatic trip();
    cs = 1'b1;
    #1;
    check("R6 gate drops with trip", gate, 1'b0);
    adv(1);
    cs = 1'b0;
    check("R6 gate stays off", gate, 1'b0);
  endtask

  task automatic t_power_up();
    rst = 1'b1; hi = 1'b0; lo = 1'b0; cs = 1'b0; sat = 1'b0; ss = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 gate in reset", gate, 1'b0);
    check("R1 strobe in reset", strobe, 1'b0);
    check("R1 pullup in reset", pu, 1'b0);
    rst = 1'b0; ncyc = 0;
    goto(P - 1); check("R2 no turn-on before first period end", gate, 1'b0);
    goto(P);     check("R2 first turn-on", gate, 1'b1);
    check("R10 strobe at first turn-on", strobe, 1'b1);
    goto(P + 1); check("R10 strobe one cycle", strobe, 1'b0);
  endtask

  task automatic t_valley();
    do_reset(1'b0, 1'b0);
    goto(40); trip();
    goto(50); hi = 1'b1; lo = 1'b1;
    goto(52); hi = 1'b0; lo = 1'b0;
    goto(60); check("R4 early trigger discarded", gate, 1'b0);
    goto(80); check("R10 strobe at period end", strobe, 1'b1);
    goto(84); hi = 1'b1; lo = 1'b1;
    goto(86); hi = 1'b0; lo = 1'b0;
    goto(89); check("R3 gate waits out valley delay", gate, 1'b0);
    goto(90); check("R3 valley turn-on after delay", gate, 1'b1);
    check("R4 valley turn-on restarts oscillator", strobe, 1'b1);
    goto(120); check("R4 old phase gone", strobe, 1'b0);
    goto(130); check("R4 new phase period end", strobe, 1'b1);
  endtask

  task automatic t_fallback();
    do_reset(1'b0, 1'b0);
    goto(40); trip();
    goto(60); hi = 1'b1; lo = 1'b1;
    goto(62); hi = 1'b0;
    goto(119); check("R5 no turn-on before second period end", gate, 1'b0);
    goto(120); check("R5 fallback turn-on", gate, 1'b1);
    trip();
    goto(165); lo = 1'b0;
    goto(175); check("R11 stale arm does not trigger", gate, 1'b0);
    goto(199); check("R5 still off", gate, 1'b0);
    goto(200); check("R5 fallback again", gate, 1'b1);
  endtask

  task automatic t_blank();
    do_reset(1'b0, 1'b0);
    goto(117); trip();
    hi = 1'b1; lo = 1'b1;
    goto(120); hi = 1'b0; lo = 1'b0;
    goto(126); check("R7 edges in blanking ignored, fallback held", gate, 1'b0);
    goto(127); check("R7 deferred fallback at blanking end", gate, 1'b1);
    trip();
    goto(129); hi = 1'b1; lo = 1'b1;
    goto(170); hi = 1'b0; lo = 1'b0;
    goto(180); check("R7 arm during blanking lost", gate, 1'b0);
  endtask

  task automatic t_collide();
    do_reset(1'b0, 1'b0);
    goto(40); trip();
    goto(115); hi = 1'b1; lo = 1'b1;
    goto(117); hi = 1'b0; lo = 1'b0;
    goto(120); check("R3 delay running at period end", gate, 1'b0);
    check("R10 strobe at wrap", strobe, 1'b1);
    goto(121); check("R3 single valley turn-on", gate, 1'b1);
    check("R10 strobe at turn-on", strobe, 1'b1);
    trip();
    goto(140); check("R5 pending fallback consumed", gate, 1'b0);
  endtask

  task automatic t_sat();
    do_reset(1'b1, 1'b1);
    goto(1);  check("R9 soft start mutes pullup", pu, 1'b0);
    goto(10); ss = 1'b0;
    goto(11); check("R8 pullup in off-time", pu, 1'b1);
    goto(80); check("R8 slow period, no normal fallback", gate, 1'b0);
    goto(P*DIV - 1); check("R8 off before slow period end", gate, 1'b0);
    goto(P*DIV); check("R8 turn-on at slow period end", gate, 1'b1);
    check("R8 pullup off while on", pu, 1'b0);
    trip();
    check("R8 pullup back in off-time", pu, 1'b1);
    ss = 1'b1;
    adv(1); check("R9 soft start overrides saturation", pu, 1'b0);
    ss = 1'b0;
    goto(3*P*DIV - 1); check("R8 slow fallback not early", gate, 1'b0);
    goto(3*P*DIV);     check("R8 slow fallback", gate, 1'b1);
  endtask

  initial begin
    t_power_up();
    t_valley();
    t_fallback();
    t_blank();
    t_collide();
    t_sat();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule